// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three half-bridge legs. Each leg gets a positive output and a complementary negative output. Two counters trace one triangular (center-aligned) waveform: they count up to a programmed limit, reverse, count down to zero and reverse again. The lead counter starts a programmable number of counts ahead of the lag counter, and the lag counter starts at zero. Both counters advance on the same clock-enable tick, so that offset never drifts.

Each leg has a turning point. The leg's positive output is active only while both counters are above the turning point. The negative output is active only while both counters are at or below it. In between, one counter has crossed and the other has not, so both outputs sit inactive. The width of that dead band equals the counter offset, measured in ticks.

Software sets the limit and turning points directly. The initial counter values are taken only while the generator is stopped.

Top module: `tripwm_gen`

## Requirements
- R1: During and right after reset, all six outputs are 0 (inactive) and the generator is stopped.
- R2: While stopped, all six outputs are 0. Each counter continuously reloads its initial value (lead from `leadInit`, lag from `lagInit`) and its direction is set to up. A start resumes from those values.
- R3: Changes to `leadInit` or `lagInit` made while running have no effect on the running waveform.
- R4: While running, both counters step by one on every cycle with `tick` high. Neither counter moves on a cycle with `tick` low. The first cycle after the start request is registered does not step.
- R5: Each counter counts up to L = `limitReg`+1, then down to 0, then up again, with period 2L ticks. Only the limit and zero reversals alter its course, and nothing clears it.
- R6: For a turning point T with 0 < T < L, `pwmPos[k]` is 1 exactly when both counters are greater than T.
- R7: For 0 < T < L, `pwmNeg[k]` is 1 exactly when both counters are less than or equal to T.
- R8: `pwmPos[k]` and `pwmNeg[k]` are never 1 in the same cycle.
- R9: While running, T = 0 holds `pwmPos[k]`=1 and `pwmNeg[k]`=0. T >= L holds `pwmPos[k]`=0 and `pwmNeg[k]`=1.
- R10: With a tick on every cycle and a lead offset D, the negative output of a leg rises exactly D cycles after its positive output falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from a shared prescaler |
| runReq | input | 1 | 1 = run, 0 = stop (registered) |
| leadInit | input | CNT_W | Lead counter start value (dead time in ticks) |
| lagInit | input | CNT_W | Lag counter start value (normally 0) |
| limitReg | input | CNT_W | Counter upper limit minus one |
| turnPts | input | NPAIR*CNT_W | Turning point per leg, leg k at bits [k*CNT_W +: CNT_W] |
| pwmPos | output | NPAIR | Positive outputs, active high |
| pwmNeg | output | NPAIR | Negative outputs, active high |

## Verification
Two events can fall in the same cycle: a counter reversal at the limit or at zero, and a turning-point crossing on the other counter. A turning point one count below the limit, combined with a lead offset of a few ticks, places the lead counter's reversal inside the lag counter's crossing window. A turning point at the limit tests the constant-output boundary against the top reversal.

A second coincidence comes from ticks that arrive in the cycle the run request changes, including sparse tick patterns. A behavioural model follows the phase of the triangle independently, and every output is compared to it on each cycle. That comparison catches a wrong reversal, a missed step or a leg whose outputs overlap.

// File: rtl/tripwm_pkg.sv
package tripwm_pkg;
  typedef struct packed {
    logic load;   // stopped: counters take their initial values
    logic step;   // running and ticked: counters advance
  } tripwm_strobe_t;
endpackage

// File: rtl/tripwm_ctrl.sv
module tripwm_ctrl
  import tripwm_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           runReq,
  input  logic           tick,
  output logic           runQ,
  output tripwm_strobe_t strobe
);
  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= runReq;
  end

  always_comb begin
    strobe.load = ~runQ;
    strobe.step = runQ & tick;
  end
endmodule

// File: rtl/tripwm_updown.sv
module tripwm_updown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] initVal,
  input  logic [W:0]   topVal,
  output logic [W-1:0] cnt
);
  logic goingDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      goingDown <= 1'b0;
    end else if (load) begin
      cnt       <= initVal;
      goingDown <= 1'b0;
    end else if (step) begin
      if (!goingDown) begin
        if ({1'b0, cnt} >= topVal) begin
          goingDown <= 1'b1;
          cnt       <= cnt - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          goingDown <= 1'b0;
          cnt       <= cnt + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tripwm_dpath.sv
module tripwm_dpath
  import tripwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tripwm_strobe_t         strobe,
  input  logic                   runQ,
  input  logic [CNT_W-1:0]       leadInit,
  input  logic [CNT_W-1:0]       lagInit,
  input  logic [CNT_W-1:0]       limitReg,
  input  logic [NPAIR*CNT_W-1:0] turnPts,
  output logic [CNT_W-1:0]       leadCnt,
  output logic [CNT_W-1:0]       lagCnt,
  output logic [NPAIR-1:0]       pwmPos,
  output logic [NPAIR-1:0]       pwmNeg
);
  localparam int TOP_W = CNT_W + 1;

  logic [TOP_W-1:0] topVal;
  assign topVal = {1'b0, limitReg} + 1'b1;

  tripwm_updown #(.W(CNT_W)) uLead (
    .clk(clk), .rstN(rstN), .load(strobe.load), .step(strobe.step),
    .initVal(leadInit), .topVal(topVal), .cnt(leadCnt)
  );

  tripwm_updown #(.W(CNT_W)) uLag (
    .clk(clk), .rstN(rstN), .load(strobe.load), .step(strobe.step),
    .initVal(lagInit), .topVal(topVal), .cnt(lagCnt)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : gLeg
    logic [CNT_W-1:0] turn;
    logic leadAbove, lagAbove;
    assign turn      = turnPts[k*CNT_W +: CNT_W];
    assign leadAbove = leadCnt > turn;
    assign lagAbove  = lagCnt  > turn;

    always_comb begin
      if (!runQ) begin
        pwmPos[k] = 1'b0;
        pwmNeg[k] = 1'b0;
      end else if (turn == '0) begin
        pwmPos[k] = 1'b1;
        pwmNeg[k] = 1'b0;
      end else if ({1'b0, turn} >= topVal) begin
        pwmPos[k] = 1'b0;
        pwmNeg[k] = 1'b1;
      end else begin
        pwmPos[k] = leadAbove & lagAbove;
        pwmNeg[k] = ~leadAbove & ~lagAbove;
      end
    end
  end
endmodule

// File: rtl/tripwm_gen.sv
module tripwm_gen
  import tripwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   runReq,
  input  logic [CNT_W-1:0]       leadInit,
  input  logic [CNT_W-1:0]       lagInit,
  input  logic [CNT_W-1:0]       limitReg,
  input  logic [NPAIR*CNT_W-1:0] turnPts,
  output logic [NPAIR-1:0]       pwmPos,
  output logic [NPAIR-1:0]       pwmNeg
);
  tripwm_strobe_t   strobe;
  logic             runQ;
  logic [CNT_W-1:0] leadCnt;
  logic [CNT_W-1:0] lagCnt;

  tripwm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .tick(tick),
    .runQ(runQ), .strobe(strobe)
  );

  tripwm_dpath #(.CNT_W(CNT_W), .NPAIR(NPAIR)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runQ(runQ),
    .leadInit(leadInit), .lagInit(lagInit), .limitReg(limitReg),
    .turnPts(turnPts), .leadCnt(leadCnt), .lagCnt(lagCnt),
    .pwmPos(pwmPos), .pwmNeg(pwmNeg)
  );
endmodule

// File: rtl/tripwm_chk.sv
module tripwm_chk #(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             runQ,
  input logic [CNT_W-1:0] leadCnt,
  input logic [CNT_W-1:0] lagCnt,
  input logic [NPAIR-1:0] pwmPos,
  input logic [NPAIR-1:0] pwmNeg
);
  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (pwmPos & pwmNeg) == '0); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> (pwmPos == '0 && pwmNeg == '0)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !tick) |=> ($stable(leadCnt) && $stable(lagCnt))); // R4

  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && tick) |=> (leadCnt != $past(leadCnt) && lagCnt != $past(lagCnt))); // R4
endmodule

bind tripwm_gen tripwm_chk #(.CNT_W(CNT_W), .NPAIR(NPAIR)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .runQ(runQ),
  .leadCnt(leadCnt), .lagCnt(lagCnt), .pwmPos(pwmPos), .pwmNeg(pwmNeg)
);

// File: tb/tripwm_gen_test.sv
module tripwm_gen_test;
  localparam int CNT_W = 16;
  localparam int NPAIR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic runReq = 1'b0;
  logic [CNT_W-1:0] leadInit = '0;
  logic [CNT_W-1:0] lagInit = '0;
  logic [CNT_W-1:0] limitReg = '0;
  logic [NPAIR*CNT_W-1:0] turnPts = '0;
  logic [NPAIR-1:0] pwmPos, pwmNeg;

  always #5 clk = ~clk;

  tripwm_gen #(.CNT_W(CNT_W), .NPAIR(NPAIR)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .runReq(runReq),
    .leadInit(leadInit), .lagInit(lagInit), .limitReg(limitReg),
    .turnPts(turnPts), .pwmPos(pwmPos), .pwmNeg(pwmNeg)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit cmpOn = 0;
  string tag = "R2";

  // behavioural model: phase of the triangle, offset latched at start
  bit mRun = 0;
  int phase = 0;
  int offs = 0;

  // dead-band measurement on leg 1
  bit gapOn = 0;
  int lastFall = -1;
  bit prevPos1 = 0;
  bit prevNeg1 = 0;
  int gapD = 0;

  function automatic int triVal(int k, int lim);
    int m;
    m = k % (2 * lim);
    return (m <= lim) ? m : 2 * lim - m;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mRun = 0;
      phase = 0;
    end else begin
      if (!mRun) begin
        phase = 0;
        offs = int'(leadInit);
      end else if (tick) begin
        phase++;
      end
      mRun = runReq;
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual cyc=%0d expected < 20000", cyc);
      summary();
    end
    #2;
    if (cmpOn && rstN) begin
      int lim, lead, lag, t;
      bit ep, en;
      lim = int'(limitReg) + 1;
      lag = triVal(phase, lim);
      lead = triVal(phase + offs, lim);
      for (int k = 0; k < NPAIR; k++) begin
        t = int'(turnPts[k*CNT_W +: CNT_W]);
        if (!mRun) begin ep = 0; en = 0; end
        else if (t == 0) begin ep = 1; en = 0; end
        else if (t >= lim) begin ep = 0; en = 1; end
        else begin ep = (lead > t) && (lag > t); en = (lead <= t) && (lag <= t); end
        checks++;
        if (pwmPos[k] !== ep) begin
          fails++;
          $display("FAIL R6 (%s) leg %0d pos actual=%b expected=%b cyc=%0d", tag, k, pwmPos[k], ep, cyc);
        end
        checks++;
        if (pwmNeg[k] !== en) begin
          fails++;
          $display("FAIL R7 (%s) leg %0d neg actual=%b expected=%b cyc=%0d", tag, k, pwmNeg[k], en, cyc);
        end
        checks++;
        if (pwmPos[k] && pwmNeg[k]) begin
          fails++;
          $display("FAIL R8 leg %0d overlap actual=11 expected not both cyc=%0d", k, cyc);
        end
      end
      if (gapOn) begin
        if (prevPos1 && !pwmPos[1]) lastFall = cyc;
        if (!prevNeg1 && pwmNeg[1] && lastFall >= 0) begin
          checks++;
          if (cyc - lastFall != gapD) begin
            fails++;
            $display("FAIL R10 dead band actual=%0d expected=%0d", cyc - lastFall, gapD);
          end
          lastFall = -1;
        end
      end
      prevPos1 = pwmPos[1];
      prevNeg1 = pwmNeg[1];
    end
  end

  task automatic runFor(int n, int tickEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % tickEvery) == 0;
    end
  endtask

  task automatic setTurns(int a, int b, int c);
    turnPts = {CNT_W'(c), CNT_W'(b), CNT_W'(a)};
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (pwmPos !== '0 || pwmNeg !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b/%b expected=000/000", pwmPos, pwmNeg);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (pwmPos !== '0 || pwmNeg !== '0) begin
      fails++;
      $display("FAIL R1 after reset actual=%b/%b expected=000/000", pwmPos, pwmNeg);
    end

    // R2: stopped with settings in place
    limitReg = 16'd19;
    setTurns(5, 10, 15);
    leadInit = 16'd4;
    lagInit = '0;
    cmpOn = 1;
    tag = "R2";
    runFor(5, 1);

    // R6 R7 R10: continuous ticks, offset 4
    gapD = 4;
    gapOn = 1;
    tag = "R6";
    runReq = 1'b1;
    runFor(90, 1);
    gapOn = 0;

    // R3: init values change while running
    tag = "R3";
    leadInit = 16'd9;
    lagInit = 16'd7;
    runFor(30, 1);
    lagInit = '0;

    // R4: sparse ticks
    tag = "R4";
    runFor(60, 3);

    // R2: stop, then restart from fresh values
    tag = "R2";
    runReq = 1'b0;
    runFor(4, 1);
    // R5: new limit, turning point one below limit
    tag = "R5";
    limitReg = 16'd11;
    leadInit = 16'd2;
    setTurns(3, 6, 11);
    runFor(2, 1);
    runReq = 1'b1;
    runFor(100, 1);

    // R9: constant-output boundaries
    tag = "R9";
    runReq = 1'b0;
    runFor(3, 1);
    setTurns(0, 12, 20);
    runReq = 1'b1;
    runFor(60, 2);

    // stop with a tick in the same cycle
    tag = "R2";
    runReq = 1'b0;
    runFor(6, 1);

    done = 1;
    summary();
  end
endmodule